// File: doc/BRIEF.md
# Third-Order Noise-Shaping Fractional Divide Modulator

This block steers the divide ratio of a fractional-N synthesizer. An unsigned fraction word in the range [0,1) is fed to three cascaded first-order accumulators. The first accumulator adds the fraction word. Each later accumulator adds the residue that the stage before it produced in the same cycle. The overflow bits of the three stages are merged by a differencing network into a small signed offset. The external feedback divider adds this offset to its integer ratio. Over time the offsets average to the fraction, and the quantisation error is pushed to high frequencies.

A 15-bit pseudo-random sequence generator can add one least-significant bit to the first accumulator input. This keeps the carry pattern from settling into a short cycle. A mode input reduces the modulator to its first stage alone, which gives a plain periodic carry pattern. Every register is clocked by the divider output. Each rising edge with the enable high is one divider cycle, and the fraction word is taken at that edge.

Top module: `mash111_modulator`

## Requirements
- R1: While `rst_n` is low, all accumulators, carry delay registers and the output are cleared, and `offset_out` reads 0. The LFSR loads its seed. The first offset computed from live input appears at the first rising edge with `en` high after `rst_n` goes high.
- R2: In third-order mode, `offset_out` is a 4-bit two's-complement value that always lies between -3 and +4.
- R3: With `single_stage`=1 and `dither_en`=0, `offset_out` is the first-stage carry alone (0 or 1). A fraction word of 16'h6000 (3/8) gives exactly 3 ones in every 8 cycles, and the pattern repeats with period 8.
- R4: The stages are chained as follows. On each enabled edge, stage 1 adds the fraction word plus the dither bit to its accumulator. Stage k (k = 2, 3) adds stage k-1's new residue to its own accumulator. Each sum is taken modulo 2^N, and the bit that overflows out of the sum is that stage's carry. At that same edge the registered output becomes c1 + (c2 - c2') + (c3 - 2*c3' + c3''). Here c2' and c3' are the carries of the previous enabled cycle, and c3'' is the carry from two enabled cycles back.
- R5: The LFSR is a 15-bit generator. Its dither bit is state bit 14. On each enabled edge the state shifts left, and bit 0 takes bit 14 XOR bit 13. When `dither_en`=1, the dither bit is added as +1 LSB to the stage-1 sum. When `dither_en`=0, nothing is added, but the LFSR still advances.
- R6: While `en` is low, no accumulator, delay register, LFSR state or output changes, and the fraction word is ignored.
- R7: Without dither, in third-order mode, the sum of `offset_out` over the first 2^N enabled cycles after reset equals the fraction word within ±2.
- R8: With dither, in third-order mode, the sum of `offset_out` over the first 2^N enabled cycles after reset lies between the fraction word minus 2 and the fraction word plus 3.
- R9: The LFSR state is never all-zero. A seed parameter of zero is replaced by 15'h0001.
- R10: A fraction word of 0 with dither off gives `offset_out` = 0 on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback-divider output; one rising edge per divider cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the modulator on this edge |
| dither_en | input | 1 | Add the pseudo-random LSB to the stage-1 input |
| single_stage | input | 1 | 1: output the stage-1 carry only; 0: full third-order output |
| frac_word | input | FRAC_W | Unsigned fraction, value = frac_word / 2^FRAC_W |
| offset_out | output | 4 | Signed divide-ratio offset, two's complement |

## Verification
The assertions check several properties on every cycle. Each carry agrees with the way its residue wraps relative to the stage's old accumulator or its input. The output stays inside -3..+4 and is only 0 or 1 in single-stage mode. Nothing moves while the enable is low, and the LFSR never reaches zero. Other behaviour can only be shown by the bench's scenarios against an independent cycle model: the exact offset sequence, the 3-of-8 period, the zero-seed substitution, and the long-run averages over 2^16 cycles with and without dither.

// File: rtl/mash_pkg.sv
package mash_pkg;

  localparam int STAGES = 3;
  localparam int LFSR_W = 15;

  typedef logic signed [3:0] offset_t;

  // Merge carries: c1 + first difference of c2 + second difference of c3.
  // Done in 5-bit modular arithmetic; the low four bits are the signed result.
  function automatic offset_t mash_combine(input logic c1, input logic c2,
                                           input logic c2_d1, input logic c3,
                                           input logic c3_d1, input logic c3_d2);
    logic [4:0] t;
    t = {4'b0, c1} + {4'b0, c2} - {4'b0, c2_d1}
      + {4'b0, c3} - {3'b0, c3_d1, 1'b0} + {4'b0, c3_d2};
    return offset_t'(t[3:0]);
  endfunction

  // One shift of the 15-bit maximal-length generator (taps on bits 14 and 13).
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction

  // A zero state would lock the generator; substitute a legal one.
  function automatic logic [LFSR_W-1:0] lfsr_legal_seed(input logic [LFSR_W-1:0] s);
    return (s == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : s;
  endfunction

endpackage

// File: rtl/mash_accum_stage.sv
module mash_accum_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] addend,
  input  logic         lsb_in,
  output logic [W-1:0] residue,
  output logic         carry
);

  logic [W-1:0] acc_q;
  logic [W:0]   sum_w;

  assign sum_w   = {1'b0, acc_q} + {1'b0, addend} + {{W{1'b0}}, lsb_in};
  assign residue = sum_w[W-1:0];
  assign carry   = sum_w[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= residue;
  end

  // R4: an overflow leaves a residue no larger than the old accumulator
  assert_carry_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (residue <= acc_q));
  assert_no_carry_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !carry |-> (residue >= acc_q));
  // R6: accumulator frozen while disabled
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/mash_dither_lfsr.sv
module mash_dither_lfsr
  import mash_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 15'h1ACE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bit_o
);

  localparam logic [LFSR_W-1:0] START = lfsr_legal_seed(SEED);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= START;
    else if (en) state_q <= lfsr_advance(state_q);
  end

  assign bit_o = state_q[LFSR_W-1];

  // R9: the generator never falls into the all-zero lock-up state
  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R6: generator frozen while disabled
  assert_lfsr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q));

endmodule

// File: rtl/mash_carry_combiner.sv
module mash_carry_combiner
  import mash_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    single_stage,
  input  logic    c1,
  input  logic    c2,
  input  logic    c3,
  output offset_t offset_q
);

  logic c2_d1, c3_d1, c3_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      c2_d1    <= 1'b0;
      c3_d1    <= 1'b0;
      c3_d2    <= 1'b0;
    end else if (en) begin
      offset_q <= single_stage ? offset_t'({3'b0, c1})
                               : mash_combine(c1, c2, c2_d1, c3, c3_d1, c3_d2);
      c2_d1    <= c2;
      c3_d1    <= c3;
      c3_d2    <= c3_d1;
    end
  end

  // R2: third-order offset confined to -3..+4
  assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_q >= -4'sd3) && (offset_q <= 4'sd4));
  // R3: single-stage mode yields a bare carry
  assert_single_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && single_stage) |=> (offset_q == 4'sd0 || offset_q == 4'sd1));
  // R6: output held while disabled
  assert_offset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(offset_q));

endmodule

// File: rtl/mash111_modulator.sv
module mash111_modulator
  import mash_pkg::*;
#(
  parameter int                FRAC_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 15'h1ACE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                dither_en,
  input  logic                single_stage,
  input  logic [FRAC_W-1:0]   frac_word,
  output logic signed [3:0]   offset_out
);

  logic [FRAC_W-1:0] residue [STAGES];
  logic [STAGES-1:0] carry;
  logic              lfsr_bit;
  logic              dither_bit;
  offset_t           offset_w;

  mash_dither_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .bit_o (lfsr_bit)
  );

  assign dither_bit = dither_en & lfsr_bit;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [FRAC_W-1:0] stage_in;
    logic              stage_lsb;
    if (g == 0) begin : g_head
      assign stage_in  = frac_word;
      assign stage_lsb = dither_bit;
    end else begin : g_tail
      assign stage_in  = residue[g-1];
      assign stage_lsb = 1'b0;
    end
    mash_accum_stage #(.W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .addend  (stage_in),
      .lsb_in  (stage_lsb),
      .residue (residue[g]),
      .carry   (carry[g])
    );
  end

  mash_carry_combiner u_comb (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .single_stage (single_stage),
    .c1           (carry[0]),
    .c2           (carry[1]),
    .c3           (carry[2]),
    .offset_q     (offset_w)
  );

  assign offset_out = offset_w;

  // R4: the last stage's carry is consistent with its input from stage 2
  assert_tail_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry[STAGES-1] |-> (residue[STAGES-1] < residue[STAGES-2]));
  assert_tail_nocarry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !carry[STAGES-1] |-> (residue[STAGES-1] >= residue[STAGES-2]));

endmodule

// File: tb/tb_mash111_modulator.sv
`timescale 1ns/1ps
module tb_mash111_modulator;
  import mash_pkg::*;

  localparam int          W    = 16;
  localparam longint      MOD  = 64'd1 << W;
  localparam logic [14:0] SEED = 15'h1ACE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic dither_en = 1'b0;
  logic single_stage = 1'b0;
  logic [W-1:0] frac = '0;
  logic signed [3:0] out_a, out_z;

  int n_checks = 0;
  int n_fail   = 0;

  mash111_modulator #(.FRAC_W(W), .LFSR_SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dither_en(dither_en),
    .single_stage(single_stage), .frac_word(frac), .offset_out(out_a));

  mash111_modulator #(.FRAC_W(W), .LFSR_SEED(15'h0000)) dut_z (
    .clk(clk), .rst_n(rst_n), .en(en), .dither_en(dither_en),
    .single_stage(single_stage), .frac_word(frac), .offset_out(out_z));

  always #2.5 clk = ~clk;

  // independent cycle model, index 0 = dut, 1 = dut_z
  longint      m_a1 [2], m_a2 [2], m_a3 [2];
  int          m_c2p [2], m_c3p [2], m_c3pp [2], m_out [2];
  logic [14:0] m_lf [2];
  int          mism [2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_a1[i] = 0; m_a2[i] = 0; m_a3[i] = 0;
      m_c2p[i] = 0; m_c3p[i] = 0; m_c3pp[i] = 0; m_out[i] = 0;
      mism[i] = 0;
    end
    m_lf[0] = SEED;
    m_lf[1] = 15'h0001;
  endtask

  task automatic model_step(input int i);
    longint s;
    int d, c1, c2, c3;
    if (!en) return;
    d = (dither_en && m_lf[i][14]) ? 1 : 0;
    s = m_a1[i] + longint'(frac) + d;  c1 = (s >= MOD) ? 1 : 0;  m_a1[i] = s % MOD;
    s = m_a2[i] + m_a1[i];             c2 = (s >= MOD) ? 1 : 0;  m_a2[i] = s % MOD;
    s = m_a3[i] + m_a2[i];             c3 = (s >= MOD) ? 1 : 0;  m_a3[i] = s % MOD;
    if (single_stage) m_out[i] = c1;
    else m_out[i] = c1 + c2 - m_c2p[i] + c3 - 2 * m_c3p[i] + m_c3pp[i];
    m_c2p[i] = c2;
    m_c3pp[i] = m_c3p[i];
    m_c3p[i] = c3;
    m_lf[i] = (m_lf[i] << 1) | 15'((m_lf[i] >> 14) ^ ((m_lf[i] >> 13) & 15'h1));
  endtask

  // one divider cycle: edge, model update, compare at the falling edge
  task automatic step();
    @(posedge clk);
    model_step(0);
    model_step(1);
    @(negedge clk);
    if (int'(out_a) != m_out[0]) mism[0]++;
    if (int'(out_z) != m_out[1]) mism[1]++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    en = 1'b1; frac = 16'h7777; dither_en = 1'b1; single_stage = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(out_a == 4'sd0, "R1 output held at zero during reset", int'(out_a), 0);
    model_reset();
    rst_n = 1'b1;
    check(out_a == 4'sd0, "R1 output zero after reset release", int'(out_a), 0);
    step();
    check(int'(out_a) == m_out[0], "R1 first output after release", int'(out_a), m_out[0]);
  endtask

  task automatic t_first_order();
    int seq [16];
    int ones0, ones1, per_bad;
    single_stage = 1'b1; dither_en = 1'b0; en = 1'b1; frac = 16'h6000;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      step();
      seq[k] = int'(out_a);
    end
    ones0 = 0; ones1 = 0; per_bad = 0;
    for (int k = 0; k < 8; k++) begin
      ones0 += seq[k];
      ones1 += seq[k + 8];
      if (seq[k] != seq[k + 8]) per_bad++;
    end
    check(ones0 == 3, "R3 carries in first 8 cycles", ones0, 3);
    check(ones1 == 3, "R3 carries in second 8 cycles", ones1, 3);
    check(per_bad == 0, "R3 period-8 repetition", per_bad, 0);
    check(mism[0] == 0, "R3 single-stage sequence vs model", mism[0], 0);
  endtask

  task automatic t_third_order();
    logic [W-1:0] words [5] = '{16'h0001, 16'h6000, 16'h8000, 16'hFFFF, 16'h2AB3};
    int lo, hi;
    single_stage = 1'b0; dither_en = 1'b0; en = 1'b1;
    lo = 0; hi = 0;
    foreach (words[j]) begin
      frac = words[j];
      do_reset();
      for (int k = 0; k < 300; k++) begin
        step();
        if (int'(out_a) < lo) lo = int'(out_a);
        if (int'(out_a) > hi) hi = int'(out_a);
      end
      check(mism[0] == 0, $sformatf("R4 third-order sequence frac=%h", words[j]), mism[0], 0);
    end
    check(lo >= -3, "R2 minimum offset", lo, -3);
    check(hi <= 4, "R2 maximum offset", hi, 4);
  endtask

  task automatic t_zero_frac();
    int nonzero;
    single_stage = 1'b0; dither_en = 1'b0; en = 1'b1; frac = '0;
    do_reset();
    nonzero = 0;
    for (int k = 0; k < 64; k++) begin
      step();
      if (out_a != 4'sd0) nonzero++;
    end
    check(nonzero == 0, "R10 zero fraction gives zero offsets", nonzero, 0);
  endtask

  task automatic t_dither();
    single_stage = 1'b0; dither_en = 1'b1; en = 1'b1; frac = 16'h1234;
    do_reset();
    for (int k = 0; k < 2000; k++) step();
    check(mism[0] == 0, "R5 dithered sequence vs model", mism[0], 0);
    check(mism[1] == 0, "R9 zero seed replaced by 1", mism[1], 0);
  endtask

  task automatic t_enable_hold();
    int held_bad;
    logic signed [3:0] frozen;
    single_stage = 1'b0; dither_en = 1'b1; en = 1'b1; frac = 16'h3C5D;
    do_reset();
    for (int k = 0; k < 23; k++) step();
    frozen = out_a;
    en = 1'b0;
    held_bad = 0;
    for (int k = 0; k < 12; k++) begin
      frac = 16'(k * 16'h1357 + 16'h0F0F);
      step();
      if (out_a != frozen) held_bad++;
    end
    check(held_bad == 0, "R6 output frozen while disabled", held_bad, 0);
    en = 1'b1; frac = 16'h3C5D;
    for (int k = 0; k < 40; k++) step();
    check(mism[0] == 0, "R6 state unchanged across disabled cycles", mism[0], 0);
  endtask

  task automatic t_average(input bit dith, input logic [W-1:0] f);
    longint sum;
    single_stage = 1'b0; dither_en = dith; en = 1'b1; frac = f;
    do_reset();
    sum = 0;
    for (longint k = 0; k < MOD; k++) begin
      step();
      sum += longint'(out_a);
    end
    if (!dith)
      check(sum >= longint'(f) - 2 && sum <= longint'(f) + 2,
            "R7 undithered sum over 2^N cycles", int'(sum), int'(f));
    else
      check(sum >= longint'(f) - 2 && sum <= longint'(f) + 3,
            "R8 dithered sum over 2^N cycles", int'(sum), int'(f));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first_order();
    t_third_order();
    t_zero_frac();
    t_dither();
    t_enable_hold();
    t_average(1'b0, 16'h5A5A);
    t_average(1'b1, 16'h0123);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule